// File: doc/BRIEF.md
# ADC Power-Mode Sequencer

This block is the control and sequencing unit for a four-channel converter front end made of two gain-stage pairs and two converter pairs. A simple write port loads an 8-bit power register. The block turns that register into per-channel power enables for the gain stages and for the converters. It also enforces the rule that a change of converter channel count must pass through the all-off code.

When the converter code leaves the all-off state, a fixed initialization countdown runs. The countdown is measured in sample-rate ticks. While it runs, every sample word leaving the block is forced to zero, and any channel without power always reads zero. The per-sample valid strobe is delayed by one register and is never masked, so downstream framing stays aligned. When the gain-stage code leaves its all-off state, a one-cycle reset pulse goes to the gain logic.

The initialization sequencer is a three-state machine:
- `ST_OFF` is the state with converters off.
- `ST_INIT` is the countdown state.
- `ST_RUN` is the state with samples passing.

It has these transitions:
- `ST_OFF`→`ST_INIT` when the converter code becomes nonzero. The counter loads with the full tick count.
- `ST_INIT`→`ST_RUN` when a tick arrives with the count at 1.
- `ST_INIT`→`ST_OFF` when the code returns to 00. This cancels the count.
- `ST_RUN`→`ST_OFF` when the code returns to 00.

Top module: `adc_pwr_seq`

## Requirements
- R1: A write stores `wr_data[5:0]` into `reg_q[5:0]`, visible on the cycle after the write edge. `reg_q[7:6]` always reads 0.
- R2: After reset, `reg_q` = 0x1F and `seq_err` = 0. Because the converter code 11 is nonzero, `busy` rises one cycle after reset is released.
- R3: `pga_en` bit order is {stage1 right, stage1 left, stage0 right, stage0 left}. `reg_q[1:0]` decodes as follows: 00→0000, 01→0011, 10→0111, 11→1111.
- R4: `adc_en` uses the same bit order and decode as R3, with {ADC1 R, ADC1 L, ADC0 R, ADC0 L} taken from `reg_q[3:2]`. Channel k of the sample bus is `smp_in[16k+15:16k]`.
- R5: A write that moves `reg_q[3:2]` directly from one nonzero code to a different nonzero code has two effects:
  - it stores 00 in bits 3:2, keeping the other written bits;
  - it sets `seq_err`.
  Every later write sets `seq_err` to that write's own legality.
- R6: The countdown starts on the cycle after bits 3:2 become nonzero and lasts INIT_TICKS = 4128 ticks. With `fs_tick` high every cycle, `busy` stays high for exactly 4128 cycles.
- R7: While `busy` is high, every output sample word is zero.
- R8: `smp_out` is registered with one cycle of latency. A channel with its enable low outputs zero. With `busy` low and the converters up, an enabled channel passes its input unchanged.
- R9: `smp_vld_out` equals `smp_vld_in` delayed one cycle, whatever masking applies.
- R10: A write that moves `reg_q[1:0]` from 00 to a nonzero code gives a `pga_rst` pulse of exactly one cycle. The pulse appears together with the register update. No other write pulses it.
- R11: The countdown advances only on cycles with `fs_tick` high. With `fs_tick` low, `busy` holds.
- R12: If bits 3:2 return to 00 during the countdown, `busy` falls on the next cycle. The count is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| reg_q | output | 8 | Current power register |
| seq_err | output | 1 | Illegal channel-count change seen on the last write |
| fs_tick | input | 1 | Sample-rate tick |
| smp_in | input | 64 | Four 16-bit sample words, channel 0 in the low bits |
| smp_vld_in | input | 1 | Sample strobe in |
| smp_out | output | 64 | Masked sample words |
| smp_vld_out | output | 1 | Sample strobe out |
| pga_en | output | 4 | Gain-stage channel enables |
| adc_en | output | 4 | Converter channel enables |
| pga_rst | output | 1 | One-cycle gain-stage reset |
| busy | output | 1 | Initialization countdown running |

## Verification
An illegal count change and a running countdown can meet on the same edge. The forced 00 from the sequence rule must cancel the count, the error flag must set, and the unused upper bits must drop, all from one write. The bench provokes this by starting a countdown with `fs_tick` held low and then writing 0xD7 over code 11. It judges the result by `reg_q` = 0x13 and `seq_err` = 1 at the update, then `busy` low one cycle later. A second collision, between the start of the countdown and the sample mask, is judged by requiring zero output words on the very first cycle after reset.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_INIT = 2'd1,
        ST_RUN  = 2'd2
    } init_state_e;

    // Pair code to per-channel enables {pair1 R, pair1 L, pair0 R, pair0 L}
    function automatic logic [3:0] pair_decode(input logic [1:0] code);
        logic [3:0] en;
        unique case (code)
            2'b00:   en = 4'b0000;
            2'b01:   en = 4'b0011;
            2'b10:   en = 4'b0111;
            default: en = 4'b1111;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/pwr_reg.sv
module pwr_reg #(
    parameter int RW = 8,
    parameter int PW = 6,
    parameter logic [PW-1:0] RST_VAL = 6'h1F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [PW-1:0] pm_q,
    output logic          seq_err,
    output logic          gain_rst
);
    logic [1:0]    old_adc, new_adc, old_gain, new_gain;
    logic          illegal;
    logic [PW-1:0] stored;

    always_comb begin
        old_adc  = pm_q[3:2];
        new_adc  = wr_data[3:2];
        old_gain = pm_q[1:0];
        new_gain = wr_data[1:0];
        illegal  = (old_adc != 2'b00) && (new_adc != 2'b00) && (new_adc != old_adc);
        stored   = wr_data[PW-1:0];
        if (illegal) begin
            stored[3:2] = 2'b00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q     <= RST_VAL;
            seq_err  <= 1'b0;
            gain_rst <= 1'b0;
        end else begin
            gain_rst <= wr_en && (old_gain == 2'b00) && (new_gain != 2'b00);
            if (wr_en) begin
                pm_q    <= stored;
                seq_err <= illegal;
            end
        end
    end
endmodule

// File: rtl/init_seq.sv
module init_seq
    import adc_pwr_pkg::*;
#(
    parameter int INIT_TICKS = 4128,
    localparam int CW = $clog2(INIT_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_on,
    input  logic fs_tick,
    output logic busy,
    output logic ready
);
    init_state_e   state, nxt;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_OFF: begin
                    if (adc_on) begin
                        cnt <= CW'(INIT_TICKS);
                    end
                end
                ST_INIT: begin
                    if (!adc_on) begin
                        cnt <= '0;
                    end else if (fs_tick) begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // next state and outputs
    always_comb begin
        nxt   = state;
        busy  = 1'b0;
        ready = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (adc_on) nxt = ST_INIT;
            end
            ST_INIT: begin
                busy = 1'b1;
                if (!adc_on) begin
                    nxt = ST_OFF;
                end else if (fs_tick && (cnt == CW'(1))) begin
                    nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                ready = 1'b1;
                if (!adc_on) nxt = ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end
endmodule

// File: rtl/smp_mask.sv
module smp_mask #(
    parameter int SW  = 16,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic [NCH-1:0]    ch_en,
    input  logic [SW*NCH-1:0] d_in,
    input  logic              vld_in,
    output logic [SW*NCH-1:0] d_out,
    output logic              vld_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) vld_out <= 1'b0;
        else        vld_out <= vld_in;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_out[SW*k +: SW] <= '0;
            end else if (ready && ch_en[k]) begin
                d_out[SW*k +: SW] <= d_in[SW*k +: SW];
            end else begin
                d_out[SW*k +: SW] <= '0;
            end
        end
    end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int SW         = 16,
    parameter int NCH        = 4,
    parameter int INIT_TICKS = 4128,
    localparam int RW = 8,
    localparam int PW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_data,
    output logic [RW-1:0]     reg_q,
    output logic              seq_err,
    input  logic              fs_tick,
    input  logic [SW*NCH-1:0] smp_in,
    input  logic              smp_vld_in,
    output logic [SW*NCH-1:0] smp_out,
    output logic              smp_vld_out,
    output logic [NCH-1:0]    pga_en,
    output logic [NCH-1:0]    adc_en,
    output logic              pga_rst,
    output logic              busy
);
    logic [PW-1:0] pm;
    logic          ready;

    pwr_reg #(.RW(RW), .PW(PW), .RST_VAL(6'h1F)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pm_q(pm), .seq_err(seq_err), .gain_rst(pga_rst)
    );

    assign reg_q  = {{(RW-PW){1'b0}}, pm};
    assign pga_en = pair_decode(pm[1:0]);
    assign adc_en = pair_decode(pm[3:2]);

    init_seq #(.INIT_TICKS(INIT_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .adc_on(pm[3:2] != 2'b00),
        .fs_tick(fs_tick), .busy(busy), .ready(ready)
    );

    smp_mask #(.SW(SW), .NCH(NCH)) u_mask (
        .clk(clk), .rst_n(rst_n), .ready(ready), .ch_en(adc_en),
        .d_in(smp_in), .vld_in(smp_vld_in),
        .d_out(smp_out), .vld_out(smp_vld_out)
    );
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
    parameter int SW  = 16,
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        reg_q,
    input logic              seq_err,
    input logic              fs_tick,
    input logic [SW*NCH-1:0] smp_in,
    input logic              smp_vld_in,
    input logic [SW*NCH-1:0] smp_out,
    input logic              smp_vld_out,
    input logic [NCH-1:0]    pga_en,
    input logic [NCH-1:0]    adc_en,
    input logic              pga_rst,
    input logic              busy
);
    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q[7:6] == 2'b00);

    // R5
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_q[3:2] != 2'b00 && wr_data[3:2] != 2'b00 && wr_data[3:2] != reg_q[3:2])
        |=> (reg_q[3:2] == 2'b00 && seq_err));

    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pga_rst |=> !pga_rst);

    // R7
    busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (smp_out == '0));

    // R8
    off_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en[NCH-1] |=> (smp_out[SW*NCH-1 -: SW] == '0));

    // R9
    vld_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (smp_vld_out == $past(smp_vld_in)));

    // R12
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q[3:2] == 2'b00) |=> !busy);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fs_tick && reg_q[3:2] != 2'b00) |=> busy);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.SW(SW), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .reg_q(reg_q), .seq_err(seq_err), .fs_tick(fs_tick),
    .smp_in(smp_in), .smp_vld_in(smp_vld_in), .smp_out(smp_out),
    .smp_vld_out(smp_vld_out), .pga_en(pga_en), .adc_en(adc_en),
    .pga_rst(pga_rst), .busy(busy)
);

// File: tb/adc_pwr_seq_bench.sv
`timescale 1ns/1ps
module adc_pwr_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  reg_q;
    logic        seq_err;
    logic        fs_tick = 1'b1;
    logic [63:0] smp_in = '0;
    logic        smp_vld_in = 1'b0;
    logic [63:0] smp_out;
    logic        smp_vld_out;
    logic [3:0]  pga_en, adc_en;
    logic        pga_rst, busy;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    adc_pwr_seq u_adc_pwr_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .reg_q(reg_q), .seq_err(seq_err), .fs_tick(fs_tick),
        .smp_in(smp_in), .smp_vld_in(smp_vld_in), .smp_out(smp_out),
        .smp_vld_out(smp_vld_out), .pga_en(pga_en), .adc_en(adc_en),
        .pga_rst(pga_rst), .busy(busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write at a negedge; returns at the negedge after the update edge
    task automatic write_reg(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 10000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R2 reg_q", 64'(reg_q), 64'h1F);
        chk("R2 seq_err", 64'(seq_err), 64'd0);
        chk("R3 pga_en mode 11", 64'(pga_en), 64'hF);
        chk("R4 adc_en mode 11", 64'(adc_en), 64'hF);
    endtask

    task automatic t_init_count();
        int  n = 0;
        bit  seen = 0;
        bit  bad = 0;
        bit  vbad = 0;
        smp_in     = 64'h4444_3333_2222_1111;
        smp_vld_in = 1'b1;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (busy) begin
                seen = 1;
                n++;
                if (smp_out != '0) bad = 1;
                if (smp_vld_out !== 1'b1) vbad = 1;
            end else if (seen) begin
                break;
            end else begin
                chk("R2 busy rises after reset", 64'(busy), 64'd1);
            end
        end
        chk("R6 busy length", 64'(n), 64'd4128);
        chk("R7 zero while busy", 64'(bad), 64'd0);
        chk("R9 valid passes while masked", 64'(vbad), 64'd0);
    endtask

    task automatic t_pass();
        smp_in = 64'hDEAD_BEEF_0123_ABCD;
        @(negedge clk);
        chk("R8 full pass", smp_out, 64'hDEAD_BEEF_0123_ABCD);
        smp_vld_in = 1'b0;
        @(negedge clk);
        chk("R9 valid low follows", 64'(smp_vld_out), 64'd0);
        smp_vld_in = 1'b1;
    endtask

    task automatic t_illegal();
        write_reg(8'h17);
        chk("R5 forced off", 64'(reg_q), 64'h13);
        chk("R5 flag set", 64'(seq_err), 64'd1);
        chk("R4 adc_en mode 00", 64'(adc_en), 64'h0);
        @(negedge clk);
        chk("R8 unpowered zero", smp_out, 64'd0);
        write_reg(8'h11);
        chk("R5 flag cleared", 64'(seq_err), 64'd0);
        chk("R3 pga_en mode 01", 64'(pga_en), 64'h3);
        chk("R10 no pulse 11->01", 64'(pga_rst), 64'd0);
        write_reg(8'h13);
        chk("R10 no pulse 01->11", 64'(pga_rst), 64'd0);
    endtask

    task automatic t_three_ch();
        write_reg(8'h1A);
        chk("R1 stored", 64'(reg_q), 64'h1A);
        chk("R3 pga_en mode 10", 64'(pga_en), 64'h7);
        chk("R4 adc_en mode 10", 64'(adc_en), 64'h7);
        @(negedge clk);
        wait_ready();
        smp_in = 64'h5555_6666_7777_8888;
        @(negedge clk);
        chk("R8 three-channel mask", smp_out, 64'h0000_6666_7777_8888);
    endtask

    task automatic t_gain_rst();
        write_reg(8'h18);
        chk("R3 pga_en mode 00", 64'(pga_en), 64'h0);
        chk("R10 no pulse to 00", 64'(pga_rst), 64'd0);
        write_reg(8'h1B);
        chk("R10 pulse on leaving 00", 64'(pga_rst), 64'd1);
        @(negedge clk);
        chk("R10 pulse one cycle", 64'(pga_rst), 64'd0);
    endtask

    task automatic t_hold_cancel();
        write_reg(8'h13);
        fs_tick = 1'b0;
        write_reg(8'h1F);
        repeat (200) @(negedge clk);
        chk("R11 hold without tick", 64'(busy), 64'd1);
        write_reg(8'hD7);
        chk("R1 upper bits read zero", 64'(reg_q[7:6]), 64'd0);
        chk("R5 forced off during count", 64'(reg_q), 64'h13);
        chk("R5 flag set during count", 64'(seq_err), 64'd1);
        @(negedge clk);
        chk("R12 cancelled", 64'(busy), 64'd0);
        write_reg(8'h13);
        chk("R5 flag cleared again", 64'(seq_err), 64'd0);
        fs_tick = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init_count();
        t_pass();
        t_illegal();
        t_three_ch();
        t_gain_rst();
        t_hold_cancel();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule